// File: doc/BRIEF.md
# Three-Level Page Table Walker

On a miss in the translation buffer, this block turns a 32-bit virtual address into a physical address. It reads three chained page-table entries from memory. A walk starts when a request arrives with the virtual address and the root table pointer. The walker then reads one 32-bit word per level over a request/acknowledge memory port. Each read address is a table base plus a four-byte-scaled index taken from the virtual page number. The base comes from the root pointer at the first level and from the previous entry at the later levels.

The virtual page number is 20 bits wide and is split into three indices:

| Level | Index width | Virtual address bits |
|-------|-------------|----------------------|
| 1     | 8 bits      | 31:24                |
| 2     | 6 bits      | 23:18                |
| 3     | 6 bits      | 17:12                |

Bits 11:0 of the virtual address are the page offset. In every entry, bit 0 flags the entry as usable and bits 31:12 carry a frame number.

A completed walk produces a one-cycle fill pulse that carries one of two results:
- the translated physical address, or
- a fault flag, when any level holds an unusable entry.

The fill pulse is meant for loading the translation buffer. Only one walk is in flight at a time.

Top module: `pt_walker`

## Requirements
- R1: After a synchronous reset, `req_ready` is 1, `mem_req` is 0 and `fill_valid` is 0. They stay so while `req_valid` is low.
- R2: A request is taken only at a clock edge where `req_ready` is 1. While a walk is in progress, `req_ready` is 0, and `req_valid` with any address has no effect on the walk or its result.
- R3: The first read goes to `req_base + 4*VPN1`, where VPN1 is bits 31:24 of the virtual address. It is issued in the cycle after the request is taken.
- R4: The second read goes to `{E1[31:12],12'h000} + 4*VPN2`, and the third to `{E2[31:12],12'h000} + 4*VPN3`. E1 and E2 are the entries returned at levels 1 and 2, VPN2 is bits 23:18 and VPN3 is bits 17:12. Bits 11:0 of an entry never affect an address.
- R5: `mem_req` stays high with an unchanged `mem_addr` until `mem_ack`. After a non-final acknowledge, the next level's read is presented in the following cycle.
- R6: An entry whose bit 0 is 0, at any level, ends the walk. No further read is made, and the fill carries `fill_fault`=1 with `fill_paddr`=0.
- R7: After three usable entries, the fill carries `fill_fault`=0 and `fill_paddr` = `{E3[31:12], VA[11:0]}`. `fill_vpn` carries bits 31:12 of the walked virtual address.
- R8: `fill_valid` is high for exactly the one cycle after the final acknowledge, with `mem_req` low. `req_ready` returns to 1 in the cycle after that.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Walk request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_base | input | 32 | Root table byte address |
| req_ready | output | 1 | Walker idle, request can be taken |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 32 | Byte address of the entry read |
| mem_ack | input | 1 | Read completes, `mem_rdata` valid |
| mem_rdata | input | 32 | Entry returned by memory |
| fill_valid | output | 1 | One-cycle result strobe |
| fill_fault | output | 1 | Walk hit an unusable entry |
| fill_vpn | output | 20 | Virtual page number of the walk |
| fill_paddr | output | 32 | Translated physical address |

## Verification
Every output is registered, so each result appears one clock edge after its cause:
- the level-1 read address follows the accepting edge;
- each later level's address follows the edge that saw the previous acknowledge;
- the fill strobe follows the final acknowledge edge;
- the ready flag follows the fill cycle.

The bench drives on falling edges and samples on the falling edge that comes right after each of those rising edges. It computes every expected address, entry and physical address arithmetically from a hash of the read address. The sweep covers all 256 first-level indices, acknowledge delays of zero to three cycles, faults injected at each level, and requests held during busy walks.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_L1    = 3'd1,
    ST_L2    = 3'd2,
    ST_L3    = 3'd3,
    ST_DONE  = 3'd4,
    ST_FAULT = 3'd5
  } walk_st_t;
endpackage

// File: rtl/pt_idx_sel.sv
// Picks the index field for the level about to be read.
module pt_idx_sel #(
  parameter int L1_W = 8,
  parameter int L2_W = 6,
  parameter int L3_W = 6,
  localparam int VPN_W = L1_W + L2_W + L3_W,
  localparam int IDX_A = (L1_W > L2_W) ? L1_W : L2_W,
  localparam int IDX_W = (IDX_A > L3_W) ? IDX_A : L3_W
) (
  input  logic [VPN_W-1:0] vpn,
  input  logic [1:0]       lvl,
  output logic [IDX_W-1:0] idx
);
  logic [L1_W-1:0] f1;
  logic [L2_W-1:0] f2;
  logic [L3_W-1:0] f3;

  assign f1 = vpn[VPN_W-1 -: L1_W];
  assign f2 = vpn[L2_W+L3_W-1 -: L2_W];
  assign f3 = vpn[L3_W-1:0];

  always_comb begin
    case (lvl)
      2'd0:    idx = IDX_W'(f1);
      2'd1:    idx = IDX_W'(f2);
      default: idx = IDX_W'(f3);
    endcase
  end
endmodule

// File: rtl/pt_addr_form.sv
// Entry address = table base + index scaled by the entry size.
module pt_addr_form #(
  parameter int AW = 32,
  parameter int OFF_W = 12,
  parameter int IDX_W = 8,
  parameter int ENT_LOG2 = 2
) (
  input  logic             first,
  input  logic [AW-1:0]    root,
  input  logic [AW-1:0]    entry,
  input  logic [IDX_W-1:0] idx,
  output logic [AW-1:0]    addr
);
  localparam logic [AW-1:0] LOW_MASK = AW'((64'd1 << OFF_W) - 64'd1);

  logic [AW-1:0] tbase;
  logic [AW-1:0] scaled;

  assign tbase  = first ? root : (entry & ~LOW_MASK);
  assign scaled = {{(AW-IDX_W-ENT_LOG2){1'b0}}, idx, {ENT_LOG2{1'b0}}};
  assign addr   = tbase + scaled;
endmodule

// File: rtl/pt_walk_ctrl.sv
// Walk sequencing with registered memory request and fill strobe.
module pt_walk_ctrl
  import ptw_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic          mem_ack,
  input  logic          ent_valid,
  input  logic [AW-1:0] next_addr,
  output logic          ready,
  output logic          take,
  output logic [1:0]    lvl_sel,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  output logic          fill_valid,
  output logic          fill_fault,
  output logic          ok_strobe,
  output logic          bad_strobe
);
  walk_st_t st_q;
  logic     hit;

  assign ready      = (st_q == ST_IDLE);
  assign take       = req_valid && ready;
  assign hit        = mem_req && mem_ack;
  assign ok_strobe  = hit && (st_q == ST_L3) && ent_valid;
  assign bad_strobe = hit && !ent_valid;

  always_comb begin
    case (st_q)
      ST_L1:   lvl_sel = 2'd1;
      ST_L2:   lvl_sel = 2'd2;
      default: lvl_sel = 2'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= ST_IDLE;
      mem_req    <= 1'b0;
      mem_addr   <= '0;
      fill_valid <= 1'b0;
      fill_fault <= 1'b0;
    end else begin
      fill_valid <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (take) begin
            st_q     <= ST_L1;
            mem_req  <= 1'b1;
            mem_addr <= next_addr;
          end
        end
        ST_L1, ST_L2: begin
          if (hit) begin
            if (!ent_valid) begin
              st_q       <= ST_FAULT;
              mem_req    <= 1'b0;
              fill_valid <= 1'b1;
              fill_fault <= 1'b1;
            end else begin
              st_q     <= (st_q == ST_L1) ? ST_L2 : ST_L3;
              mem_addr <= next_addr;
            end
          end
        end
        ST_L3: begin
          if (hit) begin
            st_q       <= ent_valid ? ST_DONE : ST_FAULT;
            mem_req    <= 1'b0;
            fill_valid <= 1'b1;
            fill_fault <= !ent_valid;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int AW = 32,
  parameter int OFF_W = 12,
  parameter int L1_W = 8,
  parameter int L2_W = 6,
  parameter int L3_W = 6,
  parameter int ENT_LOG2 = 2,
  localparam int VPN_W = L1_W + L2_W + L3_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [AW-1:0]    req_vaddr,
  input  logic [AW-1:0]    req_base,
  output logic             req_ready,
  output logic             mem_req,
  output logic [AW-1:0]    mem_addr,
  input  logic             mem_ack,
  input  logic [AW-1:0]    mem_rdata,
  output logic             fill_valid,
  output logic             fill_fault,
  output logic [VPN_W-1:0] fill_vpn,
  output logic [AW-1:0]    fill_paddr
);
  localparam int IDX_A = (L1_W > L2_W) ? L1_W : L2_W;
  localparam int IDX_W = (IDX_A > L3_W) ? IDX_A : L3_W;
  localparam logic [AW-1:0] LOW_MASK = AW'((64'd1 << OFF_W) - 64'd1);

  logic [AW-1:0]    va_q;
  logic [VPN_W-1:0] vpn_src;
  logic [IDX_W-1:0] idx;
  logic [1:0]       lvl_sel;
  logic [AW-1:0]    next_addr;
  logic             take, ok_strobe, bad_strobe;

  assign vpn_src  = req_ready ? req_vaddr[AW-1:OFF_W] : va_q[AW-1:OFF_W];
  assign fill_vpn = va_q[AW-1:OFF_W];

  pt_idx_sel #(.L1_W(L1_W), .L2_W(L2_W), .L3_W(L3_W)) u_idx (
    .vpn(vpn_src), .lvl(lvl_sel), .idx(idx)
  );

  pt_addr_form #(.AW(AW), .OFF_W(OFF_W), .IDX_W(IDX_W), .ENT_LOG2(ENT_LOG2)) u_addr (
    .first(req_ready), .root(req_base), .entry(mem_rdata), .idx(idx), .addr(next_addr)
  );

  pt_walk_ctrl #(.AW(AW)) u_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .mem_ack(mem_ack),
    .ent_valid(mem_rdata[0]), .next_addr(next_addr), .ready(req_ready),
    .take(take), .lvl_sel(lvl_sel), .mem_req(mem_req), .mem_addr(mem_addr),
    .fill_valid(fill_valid), .fill_fault(fill_fault),
    .ok_strobe(ok_strobe), .bad_strobe(bad_strobe)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      va_q       <= '0;
      fill_paddr <= '0;
    end else begin
      if (take) va_q <= req_vaddr;
      if (ok_strobe)
        fill_paddr <= (mem_rdata & ~LOW_MASK) | (va_q & LOW_MASK);
      else if (bad_strobe)
        fill_paddr <= '0;
    end
  end
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
  parameter int AW = 32,
  parameter int VPN_W = 20
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic [AW-1:0]    req_vaddr,
  input logic [AW-1:0]    req_base,
  input logic             req_ready,
  input logic             mem_req,
  input logic [AW-1:0]    mem_addr,
  input logic             mem_ack,
  input logic [AW-1:0]    mem_rdata,
  input logic             fill_valid,
  input logic             fill_fault,
  input logic [VPN_W-1:0] fill_vpn,
  input logic [AW-1:0]    fill_paddr
);
  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (req_ready && !mem_req && !fill_valid));

  assert_busy_not_ready_R2: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> !req_ready);

  assert_take_starts_read_R3: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> (mem_req && !req_ready));

  assert_hold_until_ack_R5: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

  assert_bad_entry_faults_R6: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_ack && !mem_rdata[0]) |=> (fill_valid && fill_fault && !mem_req));

  assert_fault_zero_addr_R6: assert property (@(posedge clk) disable iff (rst)
    (fill_valid && fill_fault) |-> (fill_paddr == '0));

  assert_fill_one_cycle_R8: assert property (@(posedge clk) disable iff (rst)
    fill_valid |=> (!fill_valid && req_ready));

  assert_fill_no_read_R8: assert property (@(posedge clk) disable iff (rst)
    fill_valid |-> (!mem_req && !req_ready));
endmodule

bind pt_walker pt_walker_chk #(.AW(AW), .VPN_W(VPN_W)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_vaddr(req_vaddr),
  .req_base(req_base), .req_ready(req_ready), .mem_req(mem_req),
  .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
  .fill_valid(fill_valid), .fill_fault(fill_fault), .fill_vpn(fill_vpn),
  .fill_paddr(fill_paddr)
);

// File: tb/pt_walker_bench.sv
module pt_walker_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WALKS = 320;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic [31:0] req_base = '0;
  logic        req_ready;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        fill_valid;
  logic        fill_fault;
  logic [19:0] fill_vpn;
  logic [31:0] fill_paddr;

  int n_cmp = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pt_walker u_pt_walker (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .req_base(req_base), .req_ready(req_ready), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .fill_valid(fill_valid), .fill_fault(fill_fault), .fill_vpn(fill_vpn),
    .fill_paddr(fill_paddr)
  );

  task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // Page-table memory model: entry content is a hash of its address,
  // low bits deliberately non-zero; bit 0 forced per requested usability.
  function automatic logic [31:0] entry_of(input logic [31:0] a, input logic usable);
    logic [31:0] h;
    h = a * 32'h9E37_79B1 + 32'h7F4A_7C15;
    return {h[31:1], usable};
  endfunction

  task automatic walk(input logic [31:0] va, input logic [31:0] base, input int flt,
                      input int lat, input logic busy_poke);
    logic [31:0] exp_addr, ent, paddr;
    logic        faulted;
    faulted = 1'b0;
    paddr = '0;
    ent = '0;
    @(negedge clk);
    chk(req_ready === 1'b1, "R2 ready before request", {31'd0, req_ready}, 32'd1);
    req_valid = 1'b1;
    req_vaddr = va;
    req_base  = base;
    @(negedge clk);
    if (busy_poke) begin
      req_vaddr = ~va;
      req_base  = base ^ 32'h0F0F_0000;
    end else begin
      req_valid = 1'b0;
    end
    for (int lvl = 1; lvl <= 3; lvl++) begin
      case (lvl)
        1: exp_addr = base + {22'd0, va[31:24], 2'b00};
        2: exp_addr = {ent[31:12], 12'h000} + {24'd0, va[23:18], 2'b00};
        default: exp_addr = {ent[31:12], 12'h000} + {24'd0, va[17:12], 2'b00};
      endcase
      chk(mem_req === 1'b1, "R5 read presented", {31'd0, mem_req}, 32'd1);
      chk(mem_addr === exp_addr, (lvl == 1) ? "R3 level-1 address" : "R4 next-level address",
          mem_addr, exp_addr);
      chk(req_ready === 1'b0, "R2 busy while walking", {31'd0, req_ready}, 32'd0);
      for (int w = 0; w < lat; w++) begin
        @(negedge clk);
        chk(mem_req === 1'b1 && mem_addr === exp_addr, "R5 held until ack", mem_addr, exp_addr);
      end
      ent = entry_of(exp_addr, (lvl != flt));
      mem_ack   = 1'b1;
      mem_rdata = ent;
      @(negedge clk);
      mem_ack   = 1'b0;
      mem_rdata = 32'hDEAD_BEEF;
      if (!ent[0]) begin
        faulted = 1'b1;
        break;
      end
      if (lvl == 3) paddr = {ent[31:12], va[11:0]};
    end
    req_valid = 1'b0;
    chk(fill_valid === 1'b1, "R8 fill strobe after final ack", {31'd0, fill_valid}, 32'd1);
    chk(mem_req === 1'b0, "R6 no read after end", {31'd0, mem_req}, 32'd0);
    chk(fill_fault === faulted, faulted ? "R6 fault flag" : "R7 fault flag clear",
        {31'd0, fill_fault}, {31'd0, faulted});
    chk(fill_paddr === paddr, faulted ? "R6 zero address on fault" : "R7 physical address",
        fill_paddr, paddr);
    chk(fill_vpn === va[31:12], "R7 fill vpn", {12'd0, fill_vpn}, {12'd0, va[31:12]});
    @(negedge clk);
    chk(fill_valid === 1'b0, "R8 strobe one cycle", {31'd0, fill_valid}, 32'd0);
    chk(req_ready === 1'b1 && mem_req === 1'b0, "R8 ready again", {31'd0, req_ready}, 32'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // Reset state and idle with no request (R1)
    for (int k = 0; k < 4; k++) begin
      chk(req_ready === 1'b1 && mem_req === 1'b0 && fill_valid === 1'b0,
          "R1 idle after reset", {29'd0, req_ready, mem_req, fill_valid}, 32'd4);
      @(negedge clk);
    end
    for (int i = 0; i < WALKS; i++) begin
      logic [31:0] va, base, mix7, mix13, mix37;
      mix7  = i * 7;
      mix13 = i * 13 + 5;
      mix37 = i * 37 + 1;
      va   = {i[7:0], mix7[5:0], mix13[5:0], mix37[11:0]};
      base = 32'h1000_0000 + i * 32'h0001_0400 + {30'd0, i[1:0]} * 32'd4;
      walk(va, base, i % 4, (i / 4) % 4, (i % 7) == 3);
    end
    // Extreme indices: all-ones and all-zeros page numbers
    walk(32'hFFFF_FFFF, 32'hFFFF_F000, 0, 1, 1'b0);
    walk(32'h0000_0ABC, 32'h0000_0000, 0, 0, 1'b1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule